// File: doc/BRIEF.md
# Byte-Serial Configuration Image Loader

The loader takes a fixed-length configuration image from a host, one byte per write to a single data register, over a plain register port. The port has an address, a write strobe, a read strobe and 8-bit write and read data. Each accepted byte is placed in an on-block image store at a byte address equal to the number of bytes accepted before it. Downstream logic reads the stored image through a separate read port.

A controller with three states governs the upload. `LD_WAIT` holds the block closed while a power-up timer runs. When the timer expires, the transition *timer expiry* leads to `LD_OPEN`, where data writes are accepted and counted. When the final byte of the image is accepted, the transition *final byte* leads to `LD_SEALED`, where the image is frozen until the next reset. The status register reports the three conditions the host polls: ready, load complete and checksum pass. The data register echoes the most recently accepted byte.

The checksum is a running 8-bit sum of every accepted byte. It is judged when the final byte arrives and passes when that sum is zero modulo 256.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, the status register reads 0x00 and the data register reads 0x00.
- R2: Status bit 1 (ready) reads 0 for the first DELAY_CYCLES = (CLK_HZ/1_000_000)*DELAY_US clock edges after reset is released and reads 1 from edge DELAY_CYCLES on. A write sampled on edge DELAY_CYCLES itself is still refused.
- R3: Data-register writes made while ready is 0 are ignored: the data readback keeps its value and the byte count does not advance.
- R4: The n-th accepted byte (n counted from 0) is stored at image byte address n and is returned on `img_rdata` when `img_raddr` equals n.
- R5: A read of the data register returns the last accepted byte, however many reads are made. A read in the same cycle as a write returns the byte accepted before that write.
- R6: Status bit 2 (complete) is 0 until IMAGE_BYTES bytes have been accepted. It reads 1 from the cycle after the final byte's clock edge.
- R7: Status bit 0 (checksum) is 1 exactly when complete is 1 and the modulo-256 sum of all IMAGE_BYTES accepted bytes is zero. Otherwise it is 0.
- R8: Once complete is 1, data writes are ignored until reset: neither the readback, the status nor the stored image changes.
- R9: The status register is at offset STATUS_OFS (0) and the data register at DATA_OFS (1). Status bits 7 to 3 read 0. Any other offset reads 0x00, and `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle it is high |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read |
| img_raddr | input | IMG_AW | Byte address into the stored image |
| img_rdata | output | 8 | Stored image byte at `img_raddr` |

## Verification
Two pairs of events can land in one cycle. In the first, a data write is sampled on the very edge where the timer expires. The bench drives a write in the cycle before ready rises and expects the byte to be refused. In the second, the final image byte is written in the same cycle as a read of the data register. The bench holds the read strobe during the final write and expects the previous byte on the read port. In the next cycle it expects complete and checksum together, in one runwith a zero-sum image and in another with a non-zero sum.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;

    typedef enum logic [1:0] {
        LD_WAIT   = 2'd0,
        LD_OPEN   = 2'd1,
        LD_SEALED = 2'd2
    } ld_state_e;

    // status bit positions polled by the host
    localparam int ST_SUM_BIT   = 0;
    localparam int ST_READY_BIT = 1;
    localparam int ST_DONE_BIT  = 2;

endpackage

// File: rtl/cfgu_delay.sv
module cfgu_delay #(
    parameter  int CYCLES = 300000,
    localparam int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfgu_checksum.sv
module cfgu_checksum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         final_byte,
    input  logic [W-1:0] din,
    output logic         pass
);

    logic [W-1:0] acc_q;
    logic [W-1:0] acc_next;

    assign acc_next = acc_q + din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            pass  <= 1'b0;
        end else if (take) begin
            acc_q <= acc_next;
            if (final_byte) begin
                pass <= (acc_next == '0);
            end
        end
    end

endmodule

// File: rtl/cfgu_image_mem.sv
module cfgu_image_mem #(
    parameter  int BYTES = 7600,
    parameter  int LANES = 4,
    localparam int AW    = $clog2(BYTES),
    localparam int LW    = $clog2(LANES),
    localparam int WORDS = (BYTES + LANES - 1) / LANES
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] lane_q [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (we && (waddr[LW-1:0] == LW'(l))) begin
                bank[waddr[AW-1:LW]] <= wdata;
            end
        end

        assign lane_q[l] = bank[raddr[AW-1:LW]];
    end

    assign rdata = lane_q[raddr[LW-1:0]];

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfgu_pkg::*;
#(
    parameter  int IMAGE_BYTES  = 7600,
    parameter  int CLK_HZ       = 100_000_000,
    parameter  int DELAY_US     = 3000,
    parameter  int ADDR_W       = 4,
    parameter  int STATUS_OFS   = 0,
    parameter  int DATA_OFS     = 1,
    parameter  int LANES        = 4,
    localparam int DELAY_CYCLES = (CLK_HZ / 1_000_000) * DELAY_US,
    localparam int IMG_AW       = $clog2(IMAGE_BYTES),
    localparam int CNT_W        = $clog2(IMAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [IMG_AW-1:0] img_raddr,
    output logic [7:0]        img_rdata
);

    ld_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [7:0]       last_q;
    logic             timer_run, timer_done;
    logic             data_wr, accept, final_byte;
    logic             ready_flag, done_flag, sum_ok;
    logic [7:0]       status_w;

    assign data_wr = bus_wr && (bus_addr == ADDR_W'(DATA_OFS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_WAIT:   if (timer_done) state_d = LD_OPEN;
            LD_OPEN:   if (final_byte) state_d = LD_SEALED;
            LD_SEALED: state_d = LD_SEALED;
            default:   state_d = LD_WAIT;
        endcase
    end

    // state-derived outputs
    always_comb begin
        timer_run  = 1'b0;
        ready_flag = 1'b0;
        done_flag  = 1'b0;
        accept     = 1'b0;
        unique case (state_q)
            LD_WAIT: begin
                timer_run = 1'b1;
            end
            LD_OPEN: begin
                ready_flag = 1'b1;
                accept     = data_wr;
            end
            LD_SEALED: begin
                ready_flag = 1'b1;
                done_flag  = 1'b1;
            end
            default: begin
                timer_run = 1'b0;
            end
        endcase
        final_byte = accept && (count_q == CNT_W'(IMAGE_BYTES - 1));
    end

    // byte count and echo register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            last_q  <= '0;
        end else if (accept) begin
            count_q <= count_q + 1'b1;
            last_q  <= bus_wdata;
        end
    end

    cfgu_delay #(
        .CYCLES (DELAY_CYCLES)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (timer_done)
    );

    cfgu_checksum #(
        .W (8)
    ) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (accept),
        .final_byte (final_byte),
        .din        (bus_wdata),
        .pass       (sum_ok)
    );

    cfgu_image_mem #(
        .BYTES (IMAGE_BYTES),
        .LANES (LANES)
    ) u_mem (
        .clk   (clk),
        .we    (accept),
        .waddr (count_q[IMG_AW-1:0]),
        .wdata (bus_wdata),
        .raddr (img_raddr),
        .rdata (img_rdata)
    );

    // read mux
    always_comb begin
        status_w               = '0;
        status_w[ST_SUM_BIT]   = sum_ok;
        status_w[ST_READY_BIT] = ready_flag;
        status_w[ST_DONE_BIT]  = done_flag;
        bus_rdata              = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(STATUS_OFS)) begin
                bus_rdata = status_w;
            end else if (bus_addr == ADDR_W'(DATA_OFS)) begin
                bus_rdata = last_q;
            end
        end
    end

endmodule

// File: rtl/cfgu_checker.sv
module cfgu_checker #(
    parameter  int DELAY_CYCLES = 300000,
    parameter  int ADDR_W       = 4,
    parameter  int STATUS_OFS   = 0,
    parameter  int DATA_OFS     = 1,
    localparam int CW           = $clog2(DELAY_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              ready_flag,
    input logic              done_flag,
    input logic              sum_ok,
    input logic              accept,
    input logic [7:0]        last_q
);

    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != CW'(DELAY_CYCLES)) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    a_r2_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        ready_flag == (cyc_q == CW'(DELAY_CYCLES)));

    a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready_flag |=> ready_flag);

    a_r3_gate_early: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_flag |-> !accept);

    a_r5_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(DATA_OFS) && $past(accept))
            |-> bus_rdata == $past(bus_wdata));

    a_r6_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> ready_flag);

    a_r7_sum_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sum_ok |-> done_flag);

    a_r8_sealed_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !accept);

    a_r8_sealed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |=> ($stable(last_q) && done_flag));

    a_r9_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(STATUS_OFS)) |-> bus_rdata[7:3] == 5'd0);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'd0);

endmodule

bind cfg_image_loader cfgu_checker #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .ADDR_W       (ADDR_W),
    .STATUS_OFS   (STATUS_OFS),
    .DATA_OFS     (DATA_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ready_flag (ready_flag),
    .done_flag  (done_flag),
    .sum_ok     (sum_ok),
    .accept     (accept),
    .last_q     (last_q)
);

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;

    localparam int N      = 7600;
    localparam int CLK_HZ = 10_000_000;
    localparam int DUS    = 3000;
    localparam int D      = (CLK_HZ / 1_000_000) * DUS;
    localparam int AW     = $clog2(N);
    localparam logic [3:0] A_ST  = 4'd0;
    localparam logic [3:0] A_DAT = 4'd1;
    localparam int PROBE [8] = '{0, 1, 2, 3, 1024, 3799, N - 2, N - 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [AW-1:0] img_raddr = '0;
    logic [7:0]    img_rdata;

    int   errors = 0;
    int   checks = 0;
    int   edges  = 0;
    logic [7:0] bal;
    logic [7:0] v;

    cfg_image_loader #(
        .IMAGE_BYTES (N),
        .CLK_HZ      (CLK_HZ),
        .DELAY_US    (DUS)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .img_raddr (img_raddr),
        .img_rdata (img_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] val);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        val      = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        bus_addr  = A_DAT;
        bus_wdata = b;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic img_rd(input int a, output logic [7:0] val);
        img_raddr = AW'(a);
        #1;
        val = img_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Walks the timer window and checks the boundary cycle.
    task automatic wait_ready();
        while (edges < D - 1) @(negedge clk);
        rd_reg(A_ST, v);
        check("R2 ready low at edge D-1", int'(v[1]), 0);
        bus_addr  = A_DAT;
        bus_wdata = 8'h55;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        rd_reg(A_ST, v);
        check("R2 ready high at edge D", int'(v), 32'h02);
        rd_reg(A_DAT, v);
        check("R2 write on expiry edge refused", int'(v), 32'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] s;
        do_reset();

        // R1 reset state
        rd_reg(A_ST, v);
        check("R1 status after reset", int'(v), 32'h00);
        rd_reg(A_DAT, v);
        check("R1 data after reset", int'(v), 32'h00);

        // R3 early write ignored
        wr_byte(8'hAA);
        rd_reg(A_DAT, v);
        check("R3 early write readback", int'(v), 32'h00);
        rd_reg(A_ST, v);
        check("R3 status before ready", int'(v), 32'h00);

        // R9 decode
        rd_reg(4'd5, v);
        check("R9 unused offset", int'(v), 32'h00);
        bus_addr = A_ST;
        #1;
        check("R9 no read strobe", int'(bus_rdata), 32'h00);

        wait_ready();

        // load with zero-sum image
        s = 8'h00;
        for (int i = 0; i < N - 1; i++) begin
            wr_byte(pat(i));
            s = s + pat(i);
            if (i == 0) begin
                rd_reg(A_DAT, v);
                check("R5 first byte echo", int'(v), int'(pat(0)));
                rd_reg(A_DAT, v);
                check("R5 repeated read", int'(v), int'(pat(0)));
            end
        end
        bal = 8'(8'd0 - s);
        rd_reg(A_ST, v);
        check("R6 not complete one byte short", int'(v), 32'h02);

        // final byte together with a data read
        bus_addr  = A_DAT;
        bus_wdata = bal;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        #1;
        check("R5 read during write returns prior", int'(bus_rdata), int'(pat(N - 2)));
        bus_rd    = 1'b0;
        @(negedge clk);
        bus_wr    = 1'b0;
        rd_reg(A_ST, v);
        check("R6 R7 complete with pass", int'(v), 32'h07);
        rd_reg(A_DAT, v);
        check("R5 final byte echo", int'(v), int'(bal));

        // R8 sealed
        wr_byte(8'h99);
        rd_reg(A_DAT, v);
        check("R8 readback frozen", int'(v), int'(bal));
        rd_reg(A_ST, v);
        check("R8 status frozen", int'(v), 32'h07);

        // R4 image probes (index 0 also proves the early writes did not count: R3)
        for (int k = 0; k < 8; k++) begin
            int idx;
            logic [7:0] e;
            idx = PROBE[k];
            e = (idx == N - 1) ? bal : pat(idx);
            img_rd(idx, v);
            check($sformatf("R4 image byte %0d", idx), int'(v), int'(e));
        end

        // second run: non-zero sum
        do_reset();
        rd_reg(A_ST, v);
        check("R1 status after second reset", int'(v), 32'h00);
        wait_ready();
        for (int i = 0; i < N - 1; i++) wr_byte(pat(i));
        rd_reg(A_ST, v);
        check("R7 no pass before complete", int'(v), 32'h02);
        wr_byte(8'(bal + 8'd1));
        rd_reg(A_ST, v);
        check("R7 complete with failing sum", int'(v), 32'h06);
        img_rd(N - 1, v);
        check("R4 last image byte", int'(v), int'(8'(bal + 8'd1)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule